// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block connects an on-chip request port to an external byte-wide asynchronous static RAM with a 19-bit address and active-low chip select, output enable and write enable strobes. A requester offers an address, write data and a read/write flag under a valid/ready handshake. The controller runs one memory access at a time and then returns a one-cycle done strobe, together with the captured byte for a read. The data bus is split into an output value, an output-enable and an input value, so that the tri-state pad sits outside the block.

Each timing rule of the memory is converted from nanoseconds to clock cycles at elaboration. The conversion rounds up, never gives less than one cycle, and uses the clock period and a speed grade: grade 0, 1 or 2 selects a 35, 45 or 55 ns cycle. Outside an access the chip is deselected. After a long enough idle stretch the controller treats the memory as being in low-power standby. The next access then starts with a recovery wait, during which chip select is low and the other two strobes are high. Output enable stays high through every write. The controller drives the bus only after the memory's outputs have had time to float.

Top module: `sram_ctl`

## Requirements
- R1: While reset is low, chip select, output enable and write enable are high, the bus drive enable is low, ready is high and done is low.
- R2: Whenever no access or recovery wait is running, all three strobes are high and the bus drive enable is low.
- R3: A read holds chip select and output enable low with write enable high for CYC_RC cycles (4 at a 10 ns clock, grade 0). The returned byte is the value on the data input during the last of those cycles.
- R4: A write holds chip select and write enable low together for WLOW cycles (4 at a 10 ns clock, grade 0), with output enable high throughout. Both strobes rise on the same clock edge.
- R5: The bus drive enable is high only while write enable is low. It goes high no earlier than the start of the third write-enable-low cycle (offset 2 at the defaults) and falls on the same edge where write enable rises. While it is high, the output data equals the write data that was accepted.
- R6: Ready is high only while the controller is idle. Between two accesses there is at least one cycle with all strobes high. A request is accepted on a clock edge where valid and ready are both high.
- R7: After reset, and after IDLE_LIMIT consecutive idle cycles with no request accepted (16 by default), the next access is preceded by CYC_RC cycles with chip select low and output enable and write enable high. After a shorter idle stretch, no such wait is inserted.
- R8: While chip select is low, the memory address is stable and equals the address of the accepted request, even if the request inputs change.
- R9: Done is high for exactly one cycle, the cycle right after the access ends, once for each accepted request. The returned byte is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Request byte address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle access completion strobe |
| rsp_rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Value for the data pads |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 8 | Value sampled from the data pads |

## Verification
Single reads and writes are issued after idle stretches of several lengths: just under the standby limit, exactly at it and well past it. This separates accesses that need the recovery wait from those that do not. Back-to-back requests with valid held high, and read-after-write and write-after-read pairs, show that the idle gap and the bus turnaround are kept at every change of direction. The bench drives the data input with the complement of the expected byte in every read cycle except the last one, so a capture one cycle early or late is caught. It also changes the request inputs while an access is running, which shows that the address and data were latched.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RECOV = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } ctl_state_e;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // round a nanosecond figure up to whole clocks, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned t_cycle_ns(input int unsigned g);
    return (g == 0) ? 35 : (g == 1) ? 45 : 55;
  endfunction

  function automatic int unsigned t_wpulse_ns(input int unsigned g);
    return (g == 0) ? 30 : (g == 1) ? 35 : 40;
  endfunction

  function automatic int unsigned t_dsetup_ns(input int unsigned g);
    return (g == 0) ? 18 : (g == 1) ? 20 : 25;
  endfunction

  function automatic int unsigned t_float_ns(input int unsigned g);
    return (g == 0) ? 12 : (g == 1) ? 15 : 20;
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CYC_RC = 4,
  parameter int unsigned WLOW   = 4,
  parameter int unsigned CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             acc_write,
  input  logic             standby,
  output ctl_state_e       state,
  output ctl_state_e       nstate,
  output logic [CNT_W-1:0] ncnt,
  output logic             ready,
  output logic             done,
  output logic             cap
);

  logic [CNT_W-1:0] cnt;
  logic             wr_q, wr_n;
  logic             done_n;

  always_comb begin
    nstate = state;
    ncnt   = cnt;
    wr_n   = wr_q;
    done_n = 1'b0;
    cap    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (acc) begin
          wr_n = acc_write;
          ncnt = '0;
          if (standby)        nstate = ST_RECOV;
          else if (acc_write) nstate = ST_WRITE;
          else                nstate = ST_READ;
        end
      end
      ST_RECOV: begin
        if (cnt == CNT_W'(CYC_RC - 1)) begin
          ncnt   = '0;
          nstate = wr_q ? ST_WRITE : ST_READ;
        end else begin
          ncnt = cnt + 1'b1;
        end
      end
      ST_READ: begin
        if (cnt == CNT_W'(CYC_RC - 1)) begin
          cap    = 1'b1;
          done_n = 1'b1;
          ncnt   = '0;
          nstate = ST_IDLE;
        end else begin
          ncnt = cnt + 1'b1;
        end
      end
      default: begin
        if (cnt == CNT_W'(WLOW - 1)) begin
          done_n = 1'b1;
          ncnt   = '0;
          nstate = ST_IDLE;
        end else begin
          ncnt = cnt + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      wr_q  <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nstate;
      cnt   <= ncnt;
      wr_q  <= wr_n;
      done  <= done_n;
    end
  end

  assign ready = (state == ST_IDLE);

endmodule

// File: rtl/sram_ctl_idle.sv
module sram_ctl_idle #(
  parameter int unsigned IDLE_LIMIT = 16,
  localparam int unsigned CW = $clog2(IDLE_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_idle,
  input  logic acc,
  output logic standby
);

  logic [CW-1:0] cnt, cnt_n;
  logic          sb_n;
  logic          en;

  assign en = acc | in_idle;

  always_comb begin
    cnt_n = cnt;
    sb_n  = standby;
    if (acc) begin
      cnt_n = '0;
      sb_n  = 1'b0;
    end else if (cnt == CW'(IDLE_LIMIT - 1)) begin
      sb_n = 1'b1;
    end else begin
      cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      standby <= 1'b1;
    end else if (en) begin
      cnt     <= cnt_n;
      standby <= sb_n;
    end
  end

endmodule

// File: rtl/sram_ctl_strobe.sv
module sram_ctl_strobe
  import sram_ctl_pkg::*;
#(
  parameter int unsigned DRV_DLY = 2,
  parameter int unsigned CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_state_e       nstate,
  input  logic [CNT_W-1:0] ncnt,
  output logic             cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             drv
);

  logic cs_d, oe_d, we_d, drv_d;

  always_comb begin
    cs_d  = 1'b1;
    oe_d  = 1'b1;
    we_d  = 1'b1;
    drv_d = 1'b0;
    case (nstate)
      ST_RECOV: cs_d = 1'b0;
      ST_READ: begin
        cs_d = 1'b0;
        oe_d = 1'b0;
      end
      ST_WRITE: begin
        cs_d  = 1'b0;
        we_d  = 1'b0;
        drv_d = (ncnt >= CNT_W'(DRV_DLY));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n <= 1'b1;
      oe_n <= 1'b1;
      we_n <= 1'b1;
      drv  <= 1'b0;
    end else begin
      cs_n <= cs_d;
      oe_n <= oe_d;
      we_n <= we_d;
      drv  <= drv_d;
    end
  end

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          cap,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (acc) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata_q <= '0;
    else if (cap) rdata_q <= dq_in;
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned SPEED_GRADE   = 0,
  parameter int unsigned IDLE_LIMIT    = 16,
  parameter int unsigned AW            = 19,
  parameter int unsigned DW            = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int unsigned CYC_RC  = ns_to_cyc(t_cycle_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int unsigned CYC_WP  = ns_to_cyc(t_wpulse_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int unsigned CYC_SD  = ns_to_cyc(t_dsetup_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int unsigned CYC_HZ  = ns_to_cyc(t_float_ns(SPEED_GRADE), CLK_PERIOD_NS);
  // drivers wait for the memory outputs to float, and at least one clock
  localparam int unsigned DRV_DLY = imax(1, CYC_HZ);
  // pulse width, setup after drive-on, and a full cycle time with the gap
  localparam int unsigned WLOW    = imax(imax(CYC_WP, DRV_DLY + CYC_SD), CYC_RC - 1);
  localparam int unsigned CNT_W   = $clog2(imax(CYC_RC, WLOW) + 1);

  ctl_state_e       state, nstate;
  logic [CNT_W-1:0] ncnt;
  logic             acc, cap, standby;

  assign acc = req_valid & req_ready;

  sram_ctl_seq #(.CYC_RC(CYC_RC), .WLOW(WLOW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .acc_write(req_write), .standby(standby),
    .state(state), .nstate(nstate), .ncnt(ncnt), .ready(req_ready),
    .done(rsp_done), .cap(cap)
  );

  sram_ctl_idle #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
    .clk(clk), .rst_n(rst_n), .in_idle(state == ST_IDLE), .acc(acc), .standby(standby)
  );

  sram_ctl_strobe #(.DRV_DLY(DRV_DLY), .CNT_W(CNT_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .nstate(nstate), .ncnt(ncnt),
    .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .drv(mem_dq_oe)
  );

  sram_ctl_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rst_n(rst_n), .acc(acc), .req_addr(req_addr), .req_wdata(req_wdata),
    .cap(cap), .dq_in(mem_dq_in), .addr_q(mem_addr), .wdata_q(mem_dq_out),
    .rdata_q(rsp_rdata)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe
);

  // R3
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n));

  // R4
  write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));

  // R4
  write_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $rose(mem_cs_n));

  // R5
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  // R5
  drive_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(!mem_we_n));

  // R6
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  // R6
  done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (mem_cs_n && mem_oe_n && mem_we_n));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;

  localparam int CLK_NS  = 10;
  localparam int N_ACC   = 4;   // R3 at 10 ns, grade 0
  localparam int N_WLOW  = 4;   // R4
  localparam int N_DRV   = 2;   // R5
  localparam int N_REC   = 4;   // R7
  localparam int LIMIT   = 16;  // R7

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [18:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rsp_done;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  int nchk = 0;
  int nerr = 0;
  int cycles = 0;

  always #(CLK_NS / 2) clk = ~clk;

  sram_ctl #(.CLK_PERIOD_NS(CLK_NS), .SPEED_GRADE(0), .IDLE_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  typedef struct packed {
    logic        cs, oe, we, drv, done, rdy, lastrd, chkrd, rec;
    logic [18:0] addr;
    logic [7:0]  data;
  } ent_t;

  ent_t q[$];
  bit   sb_m = 1'b1;
  int   idle_run = 0;

  function automatic logic [7:0] pat(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h cycle=%0d", tag, act, exp, cycles);
    end
  endtask

  task automatic push_access(input bit w, input logic [18:0] a, input logic [7:0] d, input bit rec);
    ent_t e;
    if (rec)
      for (int i = 0; i < N_REC; i++) begin
        e = '{cs:0, oe:1, we:1, drv:0, done:0, rdy:0, lastrd:0, chkrd:0, rec:1, addr:a, data:d};
        q.push_back(e);
      end
    if (!w) begin
      for (int i = 0; i < N_ACC; i++) begin
        e = '{cs:0, oe:0, we:1, drv:0, done:0, rdy:0, lastrd:(i == N_ACC - 1), chkrd:0, rec:0, addr:a, data:d};
        q.push_back(e);
      end
      e = '{cs:1, oe:1, we:1, drv:0, done:1, rdy:1, lastrd:0, chkrd:1, rec:0, addr:a, data:pat(a)};
      q.push_back(e);
    end else begin
      for (int i = 0; i < N_WLOW; i++) begin
        e = '{cs:0, oe:1, we:0, drv:(i >= N_DRV), done:0, rdy:0, lastrd:0, chkrd:0, rec:0, addr:a, data:d};
        q.push_back(e);
      end
      e = '{cs:1, oe:1, we:1, drv:0, done:1, rdy:1, lastrd:0, chkrd:0, rec:0, addr:a, data:d};
      q.push_back(e);
    end
  endtask

  // one clock: compare at the negative edge, advance the model, wait
  task automatic tick(output bit acc);
    ent_t e;
    e = '{cs:1, oe:1, we:1, drv:0, done:0, rdy:1, lastrd:0, chkrd:0, rec:0, addr:'0, data:'0};
    if (q.size() != 0) e = q[0];
    chk(e.rec ? "R7 cs_n" : "R2 cs_n", 32'(mem_cs_n), 32'(e.cs));
    chk("R3 oe_n", 32'(mem_oe_n), 32'(e.oe));
    chk("R4 we_n", 32'(mem_we_n), 32'(e.we));
    chk("R5 dq_oe", 32'(mem_dq_oe), 32'(e.drv));
    chk("R6 ready", 32'(req_ready), 32'(e.rdy));
    chk("R9 done", 32'(rsp_done), 32'(e.done));
    if (!e.cs) chk("R8 addr", 32'(mem_addr), 32'(e.addr));
    if (e.drv) chk("R5 dq_out", 32'(mem_dq_out), 32'(e.data));
    if (e.chkrd) chk("R3 rdata", 32'(rsp_rdata), 32'(e.data));
    mem_dq_in = e.lastrd ? pat(e.addr) : ~pat(e.addr);
    acc = req_valid && e.rdy;
    if (q.size() != 0) void'(q.pop_front());
    if (acc) begin
      push_access(req_write, req_addr, req_wdata, sb_m);
      sb_m = 1'b0;
      idle_run = 0;
    end else if (e.rdy) begin
      idle_run++;
      if (idle_run >= LIMIT) sb_m = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    cycles++;
  endtask

  task automatic idle(input int n);
    bit a;
    for (int i = 0; i < n; i++) tick(a);
  endtask

  task automatic issue(input bit w, input logic [18:0] a, input logic [7:0] d);
    bit acc;
    int guard;
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    guard = 0;
    do begin
      tick(acc);
      guard++;
    end while (!acc && guard < 100);
    if (!acc) chk("R6 accept", 32'd0, 32'd1);
    req_valid = 1'b0;
    req_write = ~w;
    req_addr  = ~a;
    req_wdata = ~d;
  endtask

  initial begin
    #(CLK_NS * 100000);
    nerr++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    mem_dq_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", 32'(mem_cs_n), 32'd1);
    chk("R1 oe_n", 32'(mem_oe_n), 32'd1);
    chk("R1 we_n", 32'(mem_we_n), 32'd1);
    chk("R1 dq_oe", 32'(mem_dq_oe), 32'd0);
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 done", 32'(rsp_done), 32'd0);
    rst_n = 1'b1;
    idle(3);
    // first access after reset takes the recovery wait (R7)
    issue(1'b0, 19'h12345, 8'h00);
    idle(N_ACC + 2);
    // back-to-back, valid held high (R6, R8)
    issue(1'b1, 19'h00001, 8'hA5);
    issue(1'b1, 19'h7FFFF, 8'h3C);
    issue(1'b0, 19'h7FFFF, 8'h00);
    issue(1'b0, 19'h00000, 8'h00);
    issue(1'b1, 19'h2AAAA, 8'hFF);
    idle(8);
    // standby boundary just under and at the limit (R7)
    idle(LIMIT - 8);
    issue(1'b1, 19'h15555, 8'h81);
    idle(N_WLOW + 1 + LIMIT - 2);
    issue(1'b0, 19'h15555, 8'h00);
    idle(N_ACC + 1 + LIMIT + 4);
    issue(1'b1, 19'h0F0F0, 8'h7E);
    idle(N_REC + N_WLOW + 1 + 30);
    issue(1'b0, 19'h40001, 8'h00);
    // alternating burst
    for (int i = 0; i < 6; i++)
      issue(i[0], 19'(i * 19'h1357 + 19'h00700), 8'(i * 37 + 5));
    idle(12);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule